// File: doc/BRIEF.md
# Split-Field Branch Target Unit with Early Cache Lookup

This block turns a 14-bit PC-relative displacement into a branch target. It starts the instruction cache read before the whole target is known. The low 12 displacement bits are not added to anything. They become the low 12 bits of the target, and they give the cache line index and word select at once. The top 2 bits are a signed page step. They are sign-extended and added only to PC bits 31..12. This narrow 20-bit add runs in the same cycle as the cache read.

In the second cycle the new upper bits are compared against the tag read in the first cycle. The block then reports a hit or a miss, the fetched instruction word and the target PC. Addresses count instruction words. The cache is direct-mapped, with 256 lines of 8 words. A fill port preloads lines, since refill logic lies outside this block. A new branch may be issued every cycle. Targets can only land within -2 to +1 pages of 4K instructions around the current page.

Top module: `bf_branch_fetch`

## Requirements
- R1: Two cycles after a strobe, target_pc_o[11:0] equals disp_i[11:0] exactly. No carry from the low bits ever reaches bit 12.
- R2: Two cycles after a strobe, target_pc_o[31:12] equals pc_upper_i plus disp_i[13:12] sign-extended (a page step of -2, -1, 0 or +1), taken modulo 2^20.
- R3: Outputs for a strobe seen at clock edge k appear after edge k+1 and not earlier. Strobes on consecutive cycles each give their own result on consecutive cycles.
- R4: A hit is reported when the line at index target[10:3] is valid and its stored tag equals {target[31:12], target[11]}. On a hit, instr_o carries word target[2:0] of that line.
- R5: A miss is reported when that line is invalid or its tag differs. On a miss, instr_o is zero.
- R6: hit_o and miss_o are never high together. For each strobe, exactly one of them is high for one cycle.
- R7: In a cycle whose result slot carries no branch, hit_o and miss_o are low, and target_pc_o and instr_o keep their values.
- R8: Reset clears every line's valid bit and drives all outputs to zero.
- R9: A fill writes line fill_index_i with tag fill_tag_i, the valid bit fill_valid_i, and word w taken from fill_words_i[32*w +: 32]. Refilling a line replaces its words, and a fill with the valid bit low invalidates the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| br_valid_i | input | 1 | Branch-taken strobe |
| pc_upper_i | input | 20 | Current PC bits 31..12 |
| disp_i | input | 14 | Displacement: [13:12] page step, [11:0] direct bits |
| fill_en_i | input | 1 | Write one cache line |
| fill_index_i | input | 8 | Line to write |
| fill_tag_i | input | 21 | Tag {addr[31:12], addr[11]} |
| fill_valid_i | input | 1 | Valid bit to store |
| fill_words_i | input | 256 | Eight words, word w at [32*w +: 32] |
| target_pc_o | output | 32 | Branch target |
| instr_o | output | 32 | Fetched word, zero on miss |
| hit_o | output | 1 | Target found in cache |
| miss_o | output | 1 | Target not in cache |

## Verification
The bench sweeps all four page steps and both 20-bit wrap directions. A design that added the full displacement, or that mishandled the sign, would land on the wrong page. It uses a low field of 0xFFF on a PC page to expose any carry leaking into bit 12. It also aims at two lines that share an index but differ in page or in bit 11; a tag that ignored bit 11 or compared the old PC page would report false hits. Back-to-back strobes, checks one cycle early and idle cycles catch a pipeline with the wrong depth, a result that lingers, or one that fails to hold. Invalidating and refilling a line shows whether the valid bit and the words really update.

// File: rtl/bf_pkg.sv
package bf_pkg;
  parameter int PC_W       = 32;
  parameter int DIRECT_W   = 12;
  parameter int DISP_W     = 14;
  parameter int INDEX_W    = 8;
  parameter int WORD_SEL_W = 3;
  parameter int INSTR_W    = 32;
endpackage

// File: rtl/bf_upper_add.sv
module bf_upper_add #(
  parameter int UPPER_W = 20,
  parameter int OFS_W   = 2
) (
  input  logic [UPPER_W-1:0] pc_upper_i,
  input  logic [OFS_W-1:0]   page_step_i,
  output logic [UPPER_W-1:0] upper_o
);
  logic [UPPER_W-1:0] step_ext;

  assign step_ext = {{(UPPER_W-OFS_W){page_step_i[OFS_W-1]}}, page_step_i};
  // wraps modulo 2^UPPER_W
  assign upper_o  = pc_upper_i + step_ext;
endmodule

// File: rtl/bf_line_store.sv
module bf_line_store #(
  parameter int INDEX_W    = 8,
  parameter int WORD_SEL_W = 3,
  parameter int TAG_W      = 21,
  parameter int INSTR_W    = 32,
  localparam int LINES      = 1 << INDEX_W,
  localparam int LINE_WORDS = 1 << WORD_SEL_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          fill_en_i,
  input  logic [INDEX_W-1:0]            fill_index_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  input  logic                          fill_valid_i,
  input  logic [LINE_WORDS*INSTR_W-1:0] fill_words_i,
  input  logic                          rd_en_i,
  input  logic [INDEX_W-1:0]            rd_index_i,
  input  logic [WORD_SEL_W-1:0]         rd_word_i,
  output logic [TAG_W-1:0]              rd_tag_o,
  output logic                          rd_valid_o,
  output logic [INSTR_W-1:0]            rd_word_o
);
  logic [TAG_W-1:0]   tag_mem  [LINES];
  logic [INSTR_W-1:0] word_mem [LINES*LINE_WORDS];
  logic [LINES-1:0]   valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (fill_en_i) begin
      valid_q[fill_index_i] <= fill_valid_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_en_i) begin
      tag_mem[fill_index_i] <= fill_tag_i;
      for (int w = 0; w < LINE_WORDS; w++) begin
        word_mem[{fill_index_i, WORD_SEL_W'(w)}] <= fill_words_i[w*INSTR_W +: INSTR_W];
      end
    end
  end

  // read launched from the direct field only, before the upper add settles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_tag_o   <= '0;
      rd_valid_o <= 1'b0;
      rd_word_o  <= '0;
    end else if (rd_en_i) begin
      rd_tag_o   <= tag_mem[rd_index_i];
      rd_valid_o <= valid_q[rd_index_i];
      rd_word_o  <= word_mem[{rd_index_i, rd_word_i}];
    end
  end

  AST_FILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_en_i |=> (valid_q[$past(fill_index_i)] == $past(fill_valid_i))); // R9
endmodule

// File: rtl/bf_resolve.sv
module bf_resolve #(
  parameter int UPPER_W  = 20,
  parameter int DIRECT_W = 12,
  parameter int TAG_W    = 21,
  parameter int INSTR_W  = 32,
  localparam int TAG_LO_W = TAG_W - UPPER_W,
  localparam int PC_W     = UPPER_W + DIRECT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s1_valid_i,
  input  logic [UPPER_W-1:0]  upper_i,
  input  logic [DIRECT_W-1:0] direct_i,
  input  logic [TAG_W-1:0]    line_tag_i,
  input  logic                line_valid_i,
  input  logic [INSTR_W-1:0]  line_word_i,
  output logic [PC_W-1:0]     target_pc_o,
  output logic [INSTR_W-1:0]  instr_o,
  output logic                hit_o,
  output logic                miss_o
);
  logic [TAG_W-1:0] want_tag;
  logic             hit_d;

  assign want_tag = {upper_i, direct_i[DIRECT_W-1 -: TAG_LO_W]};
  assign hit_d    = line_valid_i && (line_tag_i == want_tag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      target_pc_o <= '0;
      instr_o     <= '0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
    end else if (s1_valid_i) begin
      target_pc_o <= {upper_i, direct_i};
      instr_o     <= hit_d ? line_word_i : '0;
      hit_o       <= hit_d;
      miss_o      <= !hit_d;
    end else begin
      hit_o  <= 1'b0;
      miss_o <= 1'b0;
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R6
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_valid_i |=> (hit_o ^ miss_o)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_i |=> (!hit_o && !miss_o)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s1_valid_i |=> ($stable(target_pc_o) && $stable(instr_o))); // R7
  AST_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (instr_o == '0)); // R5
endmodule

// File: rtl/bf_branch_fetch.sv
module bf_branch_fetch #(
  parameter int PC_W       = bf_pkg::PC_W,
  parameter int DIRECT_W   = bf_pkg::DIRECT_W,
  parameter int DISP_W     = bf_pkg::DISP_W,
  parameter int INDEX_W    = bf_pkg::INDEX_W,
  parameter int WORD_SEL_W = bf_pkg::WORD_SEL_W,
  parameter int INSTR_W    = bf_pkg::INSTR_W,
  localparam int UPPER_W    = PC_W - DIRECT_W,
  localparam int OFS_W      = DISP_W - DIRECT_W,
  localparam int TAG_LO_W   = DIRECT_W - INDEX_W - WORD_SEL_W,
  localparam int TAG_W      = UPPER_W + TAG_LO_W,
  localparam int LINE_WORDS = 1 << WORD_SEL_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          br_valid_i,
  input  logic [UPPER_W-1:0]            pc_upper_i,
  input  logic [DISP_W-1:0]             disp_i,
  input  logic                          fill_en_i,
  input  logic [INDEX_W-1:0]            fill_index_i,
  input  logic [TAG_W-1:0]              fill_tag_i,
  input  logic                          fill_valid_i,
  input  logic [LINE_WORDS*INSTR_W-1:0] fill_words_i,
  output logic [PC_W-1:0]               target_pc_o,
  output logic [INSTR_W-1:0]            instr_o,
  output logic                          hit_o,
  output logic                          miss_o
);
  logic [UPPER_W-1:0]  upper_d, upper_q;
  logic [DIRECT_W-1:0] direct_q;
  logic                s1_valid_q;
  logic [TAG_W-1:0]    line_tag;
  logic                line_valid;
  logic [INSTR_W-1:0]  line_word;

  bf_upper_add #(.UPPER_W(UPPER_W), .OFS_W(OFS_W)) i_upper_add (
    .pc_upper_i  (pc_upper_i),
    .page_step_i (disp_i[DISP_W-1:DIRECT_W]),
    .upper_o     (upper_d)
  );

  bf_line_store #(
    .INDEX_W(INDEX_W), .WORD_SEL_W(WORD_SEL_W), .TAG_W(TAG_W), .INSTR_W(INSTR_W)
  ) i_line_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_en_i    (fill_en_i),
    .fill_index_i (fill_index_i),
    .fill_tag_i   (fill_tag_i),
    .fill_valid_i (fill_valid_i),
    .fill_words_i (fill_words_i),
    .rd_en_i      (br_valid_i),
    .rd_index_i   (disp_i[WORD_SEL_W +: INDEX_W]),
    .rd_word_i    (disp_i[WORD_SEL_W-1:0]),
    .rd_tag_o     (line_tag),
    .rd_valid_o   (line_valid),
    .rd_word_o    (line_word)
  );

  // stage 1: upper add result and direct bits captured alongside the cache read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      upper_q    <= '0;
      direct_q   <= '0;
    end else begin
      s1_valid_q <= br_valid_i;
      if (br_valid_i) begin
        upper_q  <= upper_d;
        direct_q <= disp_i[DIRECT_W-1:0];
      end
    end
  end

  bf_resolve #(
    .UPPER_W(UPPER_W), .DIRECT_W(DIRECT_W), .TAG_W(TAG_W), .INSTR_W(INSTR_W)
  ) i_resolve (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .s1_valid_i   (s1_valid_q),
    .upper_i      (upper_q),
    .direct_i     (direct_q),
    .line_tag_i   (line_tag),
    .line_valid_i (line_valid),
    .line_word_i  (line_word),
    .target_pc_o  (target_pc_o),
    .instr_o      (instr_o),
    .hit_o        (hit_o),
    .miss_o       (miss_o)
  );

  AST_DIRECT_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |-> ##2 (target_pc_o[DIRECT_W-1:0] == $past(disp_i[DIRECT_W-1:0], 2))); // R1
  AST_RESULT_LATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |-> ##2 (hit_o || miss_o)); // R3
endmodule

// File: tb/test_bf_branch_fetch.sv
module test_bf_branch_fetch;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         br_valid_i = 1'b0;
  logic [19:0]  pc_upper_i = '0;
  logic [13:0]  disp_i = '0;
  logic         fill_en_i = 1'b0;
  logic [7:0]   fill_index_i = '0;
  logic [20:0]  fill_tag_i = '0;
  logic         fill_valid_i = 1'b0;
  logic [255:0] fill_words_i = '0;
  logic [31:0]  target_pc_o, instr_o;
  logic         hit_o, miss_o;

  int checks = 0;
  int errors = 0;

  logic [20:0] m_tag   [256];
  logic        m_valid [256];
  logic [31:0] m_base  [256];

  always #4ns clk = ~clk;

  bf_branch_fetch i_bf_branch_fetch (
    .clk_i(clk), .rst_ni(rst_ni), .br_valid_i(br_valid_i),
    .pc_upper_i(pc_upper_i), .disp_i(disp_i),
    .fill_en_i(fill_en_i), .fill_index_i(fill_index_i), .fill_tag_i(fill_tag_i),
    .fill_valid_i(fill_valid_i), .fill_words_i(fill_words_i),
    .target_pc_o(target_pc_o), .instr_o(instr_o), .hit_o(hit_o), .miss_o(miss_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_target(input logic [19:0] up, input logic [13:0] d);
    return {up + {{18{d[13]}}, d[13:12]}, d[11:0]};
  endfunction

  function automatic bit f_hit(input logic [31:0] t);
    return m_valid[t[10:3]] && (m_tag[t[10:3]] == {t[31:12], t[11]});
  endfunction

  function automatic logic [31:0] f_instr(input logic [31:0] t);
    return f_hit(t) ? m_base[t[10:3]] + 32'(t[2:0]) : 32'h0;
  endfunction

  task automatic fill_line(input logic [7:0] idx, input logic [20:0] tag, input bit vld,
                           input logic [31:0] base);
    @(negedge clk);
    fill_en_i = 1'b1; fill_index_i = idx; fill_tag_i = tag; fill_valid_i = vld;
    for (int w = 0; w < 8; w++) fill_words_i[w*32 +: 32] = base + 32'(w);
    @(negedge clk);
    fill_en_i = 1'b0;
    m_tag[idx] = tag; m_valid[idx] = vld; m_base[idx] = base;
  endtask

  task automatic check_result(input logic [31:0] t, input string req);
    chk(target_pc_o == t, {req, " target"}, 64'(target_pc_o), 64'(t));
    chk(hit_o == f_hit(t), {req, " hit R4"}, 64'(hit_o), 64'(f_hit(t)));
    chk(miss_o == !f_hit(t), {req, " miss R5"}, 64'(miss_o), 64'(!f_hit(t)));
    chk(instr_o == f_instr(t), {req, " instr R4/R5"}, 64'(instr_o), 64'(f_instr(t)));
    chk(!(hit_o && miss_o), "R6 exclusive", 64'({hit_o, miss_o}), 64'h0);
  endtask

  // single branch: drive, confirm nothing moves after one edge, check after two
  task automatic branch(input logic [19:0] up, input logic [13:0] d, input string req);
    logic [31:0] prev_t;
    prev_t = target_pc_o;
    @(negedge clk);
    br_valid_i = 1'b1; pc_upper_i = up; disp_i = d;
    @(negedge clk);
    br_valid_i = 1'b0;
    chk(!hit_o && !miss_o && target_pc_o == prev_t, "R3 early", 64'(target_pc_o), 64'(prev_t));
    @(negedge clk);
    check_result(f_target(up, d), req);
  endtask

  task automatic t_reset_state;
    chk(target_pc_o == 0 && instr_o == 0, "R8 outputs", 64'({target_pc_o, instr_o}), 64'h0);
    chk(!hit_o && !miss_o, "R8 flags", 64'({hit_o, miss_o}), 64'h0);
    branch(20'h00123, 14'h002B, "R8 cold line");
  endtask

  task automatic t_hit_basic;
    fill_line(8'd5, {20'h00123, 1'b0}, 1'b1, 32'hA500_0000);
    branch(20'h00123, 14'h002B, "R4 R1 R2 hit");
  endtask

  task automatic t_misses;
    branch(20'h00123, 14'h0048, "R5 unfilled");
    branch(20'h00124, 14'h002B, "R5 other page");
    branch(20'h00123, 14'h082B, "R5 bit11 tag");
  endtask

  task automatic t_page_steps;
    for (int s = 0; s < 4; s++) begin
      logic [1:0]  st = 2'(s);
      logic [13:0] d  = {st, 1'b1, 8'd20, 3'd6};
      logic [31:0] t  = f_target(20'h00800, d);
      fill_line(8'd20, {t[31:12], t[11]}, 1'b1, 32'h2000_0000 + 32'(s << 8));
      branch(20'h00800, d, "R2 page step");
    end
  endtask

  task automatic t_wrap;
    branch(20'h00000, 14'h3000, "R2 wrap down");
    fill_line(8'd7, {20'h00000, 1'b0}, 1'b1, 32'h0700_0000);
    branch(20'hFFFFF, {2'b01, 1'b0, 8'd7, 3'd1}, "R2 wrap up");
  endtask

  task automatic t_no_carry;
    branch(20'h00123, 14'h0FFF, "R1 no carry");
  endtask

  task automatic t_idle_hold;
    logic [31:0] t, w;
    branch(20'h00123, 14'h002B, "R7 setup");
    t = target_pc_o; w = instr_o;
    pc_upper_i = 20'h55555; disp_i = 14'h3FFF;
    repeat (3) @(negedge clk);
    chk(!hit_o && !miss_o, "R7 quiet", 64'({hit_o, miss_o}), 64'h0);
    chk(target_pc_o == t && instr_o == w, "R7 hold", 64'({target_pc_o, instr_o}), 64'({t, w}));
  endtask

  task automatic t_refill;
    fill_line(8'd5, {20'h00123, 1'b0}, 1'b0, 32'hA500_0000);
    branch(20'h00123, 14'h002B, "R9 invalidated");
    fill_line(8'd5, {20'h00123, 1'b0}, 1'b1, 32'hB600_0000);
    branch(20'h00123, 14'h002C, "R9 new words");
  endtask

  task automatic t_back_to_back;
    logic [19:0] ups [3];
    logic [13:0] ds  [3];
    ups[0] = 20'h00123; ds[0] = 14'h002D;
    ups[1] = 20'h00999; ds[1] = 14'h0123;
    ups[2] = 20'hFFFFF; ds[2] = {2'b01, 1'b0, 8'd7, 3'd4};
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (c >= 2) check_result(f_target(ups[c-2], ds[c-2]), "R3 back to back");
      if (c < 3) begin
        br_valid_i = 1'b1; pc_upper_i = ups[c]; disp_i = ds[c];
      end else begin
        br_valid_i = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_base[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset_state();
    t_hit_basic();
    t_misses();
    t_page_steps();
    t_wrap();
    t_no_carry();
    t_idle_hold();
    t_refill();
    t_back_to_back();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule